// File: doc/BRIEF.md
# Fractional Clock-Ratio Enable Generator

This block produces a single-cycle transfer enable. A FIFO uses it to insert or extract data at a programmable fraction of the local clock rate. The rate comes from a bit mask and a pattern length. Each local clock cycle the block steps to the next bit position of the mask, and it raises the enable when that bit is 1. After the last position of the pattern it wraps to position 0. Because the mask can be any pattern, it sets the average rate and also the way enables cluster in time.

The mask and the length are staged continuously from the inputs. They replace the active pattern only when the walk wraps to position 0, or when a restart is requested, so a running pattern is never cut off partway through. Alongside the enable, the block outputs the current position and a flag. The flag tells a consumer whether the active pattern can produce two enables on consecutive cycles, which is the worst case an unload pointer must allow for.

Top module: `frac_rate_gen`

## Requirements
- R1: Synchronous reset (`rst` high) sets the position to 0 and loads the default pattern 0x0000FFFF with length 16, so the enable is high on every cycle. The burst flag reads 1.
- R2: Each clock cycle without restart, the position advances by one. After position length−1 it returns to 0.
- R3: The enable is high in exactly those cycles where bit p of the active mask is 1, where p is the current position. Mask bits at positions at or above the length have no effect.
- R4: A length input of 0 is treated as length 1.
- R5: A length input above 32 is treated as 32.
- R6: With `restart_i` high at a clock edge, the position is 0 after that edge and the staged mask and length become active at once.
- R7: Changes on `num_i` and `den_i` reach the enable, the position sequence and the burst flag only at the edge where the position wraps to 0, or at a restart.
- R8: The burst flag is 1 exactly when the active pattern has two neighbouring 1 bits among positions 0..length−1. The pair made of position length−1 and position 0 counts as neighbours. For length 1 that pair is bit 0 with itself.
- R9: While the burst flag is 0, the enable is never high on two consecutive cycles within one pass of the pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous restart of the walk, loads the staged pattern |
| num_i | input | PAT_W | Staged enable mask, bit i stands for position i |
| den_i | input | DEN_W | Staged pattern length |
| xfer_en_o | output | 1 | Registered transfer enable for the current cycle |
| bit_idx_o | output | $clog2(PAT_W) | Registered current position in the pattern |
| burst2_o | output | 1 | Active pattern contains neighbouring 1 bits, wrap pair included |

## Verification
The bench builds the block with the default parameters: a 32-bit mask and a 6-bit length input. The 6-bit input makes the lengths 0 and 33 to 63 reachable, so both clamps are exercised. Every mask over the lengths 1 to 6 is swept exhaustively, with the unused upper bits forced to 1 to show they are ignored. This sweep covers every combination of neighbouring pairs, including the wrap pair. Full 32-position patterns, a mid-pattern change of the inputs and the post-reset default pass complete the coverage of the loading rules.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

  // Reason the active pattern is replaced at the coming edge.
  typedef enum logic [1:0] {
    LOAD_NONE    = 2'd0,
    LOAD_WRAP    = 2'd1,
    LOAD_RESTART = 2'd2
  } load_cause_e;

endpackage

// File: rtl/frac_rate_len_clamp.sv
module frac_rate_len_clamp #(
  parameter int PAT_W = 32,
  parameter int DEN_W = 6,
  parameter int LEN_W = $clog2(PAT_W + 1)
) (
  input  logic [DEN_W-1:0] den_i,
  output logic [LEN_W-1:0] len_o
);

  // Length is kept in 1..PAT_W.
  always_comb begin
    if (den_i == '0) begin
      len_o = LEN_W'(1);
    end else if (int'(den_i) > PAT_W) begin
      len_o = LEN_W'(PAT_W);
    end else begin
      len_o = LEN_W'(den_i);
    end
  end

endmodule

// File: rtl/frac_rate_adjacency.sv
module frac_rate_adjacency #(
  parameter int PAT_W = 32,
  parameter int LEN_W = $clog2(PAT_W + 1),
  parameter int IDX_W = $clog2(PAT_W)
) (
  input  logic [PAT_W-1:0] pat_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             adj_o
);

  logic [PAT_W-1:0] hits;

  // Linear pairs (i, i+1) that lie inside the active length.
  for (genvar i = 0; i < PAT_W - 1; i++) begin : g_pair
    assign hits[i] = pat_i[i] & pat_i[i+1] & (LEN_W'(i + 1) < len_i);
  end

  // Wrap pair: last active position followed by position 0.
  assign hits[PAT_W-1] = pat_i[0] & pat_i[IDX_W'(len_i - LEN_W'(1))];

  assign adj_o = |hits;

endmodule

// File: rtl/frac_rate_walker.sv
module frac_rate_walker
  import frac_rate_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int LEN_W = $clog2(PAT_W + 1),
  parameter int IDX_W = $clog2(PAT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  idx_next_o,
  output load_cause_e       cause_o
);

  logic [IDX_W-1:0] idx_q;
  logic             at_last;

  assign at_last = (LEN_W'(idx_q) + LEN_W'(1)) == len_i;

  always_comb begin
    if (restart_i) begin
      cause_o = LOAD_RESTART;
    end else if (at_last) begin
      cause_o = LOAD_WRAP;
    end else begin
      cause_o = LOAD_NONE;
    end
  end

  assign idx_next_o = (cause_o == LOAD_NONE) ? idx_q + IDX_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_next_o;
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import frac_rate_pkg::*;
#(
  parameter int               PAT_W   = 32,
  parameter int               DEN_W   = 6,
  parameter logic [PAT_W-1:0] DEF_NUM = 'hFFFF,
  parameter int               DEF_DEN = 16,
  localparam int              IDX_W   = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [PAT_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             xfer_en_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             burst2_o
);

  localparam int LEN_W = $clog2(PAT_W + 1);
  localparam int DEF_LEN_INT = (DEF_DEN < 1) ? 1 : ((DEF_DEN > PAT_W) ? PAT_W : DEF_DEN);
  localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(DEF_LEN_INT);

  logic [PAT_W-1:0] act_num_q;
  logic [LEN_W-1:0] act_len_q;
  logic             en_q;
  logic             burst_q;

  logic [LEN_W-1:0] stage_len;
  logic             stage_adj;
  logic             def_adj;
  logic [IDX_W-1:0] idx_cur;
  logic [IDX_W-1:0] idx_next;
  load_cause_e      cause;
  logic             load;

  frac_rate_len_clamp #(
    .PAT_W (PAT_W),
    .DEN_W (DEN_W),
    .LEN_W (LEN_W)
  ) clamp_i (
    .den_i (den_i),
    .len_o (stage_len)
  );

  frac_rate_adjacency #(
    .PAT_W (PAT_W),
    .LEN_W (LEN_W),
    .IDX_W (IDX_W)
  ) stage_adj_i (
    .pat_i (num_i),
    .len_i (stage_len),
    .adj_o (stage_adj)
  );

  frac_rate_adjacency #(
    .PAT_W (PAT_W),
    .LEN_W (LEN_W),
    .IDX_W (IDX_W)
  ) def_adj_i (
    .pat_i (DEF_NUM),
    .len_i (DEF_LEN),
    .adj_o (def_adj)
  );

  frac_rate_walker #(
    .PAT_W (PAT_W),
    .LEN_W (LEN_W),
    .IDX_W (IDX_W)
  ) walker_i (
    .clk        (clk),
    .rst        (rst),
    .restart_i  (restart_i),
    .len_i      (act_len_q),
    .idx_o      (idx_cur),
    .idx_next_o (idx_next),
    .cause_o    (cause)
  );

  assign load = (cause != LOAD_NONE);

  // Active pattern is swapped only at a wrap or a restart.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_num_q <= DEF_NUM;
      act_len_q <= DEF_LEN;
      burst_q   <= def_adj;
      en_q      <= DEF_NUM[0];
    end else if (load) begin
      act_num_q <= num_i;
      act_len_q <= stage_len;
      burst_q   <= stage_adj;
      en_q      <= num_i[0];
    end else begin
      en_q      <= act_num_q[idx_next];
    end
  end

  assign xfer_en_o = en_q;
  assign bit_idx_o = idx_cur;
  assign burst2_o  = burst_q;

endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
  parameter int               PAT_W   = 32,
  parameter logic [PAT_W-1:0] DEF_NUM = 'hFFFF,
  parameter int               IDX_W   = $clog2(PAT_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             restart_i,
  input logic             xfer_en_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic             burst2_o
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (bit_idx_o == '0 && xfer_en_o == DEF_NUM[0]));

  assert_step_or_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> (bit_idx_o == '0 || bit_idx_o == $past(bit_idx_o) + IDX_W'(1)));

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (bit_idx_o == '0));

  assert_hold_until_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_idx_o != '0) |-> $stable(burst2_o));

  assert_no_pair_when_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!burst2_o && bit_idx_o != '0 && $past(xfer_en_o)) |-> !xfer_en_o);

endmodule

bind frac_rate_gen frac_rate_gen_chk #(
  .PAT_W   (PAT_W),
  .DEF_NUM (DEF_NUM),
  .IDX_W   (IDX_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .restart_i (restart_i),
  .xfer_en_o (xfer_en_o),
  .bit_idx_o (bit_idx_o),
  .burst2_o  (burst2_o)
);

// File: tb/frac_rate_gen_tb_top.sv
module frac_rate_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart_r = 1'b0;
  logic [31:0] num_r = 32'h1;
  logic [5:0]  den_r = 6'd3;
  logic        en_w;
  logic [4:0]  idx_w;
  logic        burst_w;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frac_rate_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_r),
    .num_i     (num_r),
    .den_i     (den_r),
    .xfer_en_o (en_w),
    .bit_idx_o (idx_w),
    .burst2_o  (burst_w)
  );

  function automatic int exp_len(input int d);
    if (d == 0) return 1;
    if (d > 32) return 32;
    return d;
  endfunction

  function automatic int exp_adj(input logic [31:0] n, input int l);
    for (int i = 0; i < l - 1; i++) if (n[i] && n[i+1]) return 1;
    if (n[l-1] && n[0]) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Check one cycle of a pattern at position k.
  task automatic check_cycle(input string req, input logic [31:0] n, input int l, input int k);
    check(req, "position", int'(idx_w), k % l);
    check(req, "enable", int'(en_w), int'(n[k % l]));
    check(req, "burst flag", int'(burst_w), exp_adj(n, l));
  endtask

  // Restart into a new pattern and follow it for a number of cycles.
  task automatic run_cfg(input string req, input logic [31:0] n, input int d, input int cycles);
    int l;
    l = exp_len(d);
    num_r = n;
    den_r = 6'(d);
    restart_r = 1'b1;
    @(negedge clk);
    restart_r = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      check_cycle(req, n, l, k);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, with other values already staged on the inputs.
    repeat (3) @(negedge clk);
    check("R1", "reset position", int'(idx_w), 0);
    check("R1", "reset enable", int'(en_w), 1);
    check("R1", "reset burst flag", int'(burst_w), 1);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      check_cycle("R1", 32'h0000FFFF, 16, k);
    end
    // R7: staged pattern 001/len 3 becomes active only at the wrap.
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_cycle("R7", 32'h1, 3, k);
    end

    // R3 R8: every mask for lengths 1..6, unused high bits forced to 1.
    for (int d = 1; d <= 6; d++) begin
      for (int p = 0; p < (1 << d); p++) begin
        logic [31:0] m;
        m = (32'hFFFFFFFF << d) | 32'(p);
        run_cfg("R3", m, d, 2 * d + 1);
      end
    end

    // R4: zero length behaves as one.
    run_cfg("R4", 32'h0000_0001, 0, 4);
    run_cfg("R4", 32'hFFFF_FFFE, 0, 4);

    // R5: lengths above 32 clamp to 32.
    run_cfg("R5", 32'h8000_0001, 33, 34);
    run_cfg("R5", 32'hAAAA_AAAA, 63, 34);
    run_cfg("R8", 32'h5555_5555, 32, 33);
    run_cfg("R8", 32'hC000_0000, 32, 33);

    // R6: restart in mid-pattern returns to position 0 and loads at once.
    run_cfg("R6", 32'h2D, 6, 4);
    run_cfg("R6", 32'h6, 4, 9);

    // R7: mid-pattern change is held off until the wrap.
    run_cfg("R7", 32'h16, 5, 3);
    num_r = 32'h2;
    den_r = 6'd3;
    for (int k = 3; k < 5; k++) begin
      @(negedge clk);
      check_cycle("R7", 32'h16, 5, k);
    end
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      check_cycle("R7", 32'h2, 3, k);
    end

    // R9: isolated ones never give back-to-back enables.
    run_cfg("R9", 32'h0000_0249, 12, 25);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule